// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte enters through a valid/ready stream port and is held in a one-entry holding register. It then moves into a frame shifter, which drives the line one bit period at a time. A frame is a low start bit, then seven or eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A 3-bit format code picks the shape of the frame from a fixed table of eight entries. The frame is captured at the moment it starts, so later changes to the format code do not alter a frame that is already on the line.

The bit period comes from a stream of transmit clock ticks. Each tick is a single-cycle `tick_in` pulse in the system clock domain. A 2-bit rate select divides the ticks by 1, 16 or 64. The fourth value of the rate select is a master reset that empties the holding register and forces the line idle. An active-low clear-to-send input allows new frames to start. While it is high, no frame begins, but a frame already in flight finishes.

Back-pressure: `s_ready` is the holding-register-empty flag. A byte is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` stays low until that byte has moved into the shifter, and it is held low during a master reset. The producer may keep `s_valid` and `s_data` stable for as long as it likes while `s_ready` is low.

Top module: `tx_async_framer`

## Requirements
- R1: A frame starts with one bit at 0, then the data bits least significant bit first, and ends with its stop bits at 1. The start bit appears on the first bit-period boundary at which a held byte is moved into the shifter.
- R2: `fmt_sel` selects the data length, parity and stop-bit count. The codes are: 000 = 7 data bits, even parity, 2 stops; 001 = 7, odd, 2; 010 = 7, even, 1; 011 = 7, odd, 1; 100 = 8, no parity, 2; 101 = 8, none, 1; 110 = 8, even, 1; 111 = 8, odd, 1.
- R3: Every bit on `txd_out` lasts exactly N `tick_in` pulses. N is 1 for `div_sel`=00, 16 for 01 and 64 for 10. `txd_out` changes only at those boundaries.
- R4: `s_ready` drops in the cycle after an accepted write. It rises again in the cycle after the held byte moves into the shifter, which is also the first cycle of that frame's start bit.
- R5: `div_sel`=11 is a master reset. From the next cycle, `txd_out` is 1, any frame in flight is abandoned and the held byte is discarded. `s_ready` is low while the reset is held and high once it is released.
- R6: `txd_out` is 1 while no frame is being sent, and it is 1 throughout `rst_n` reset.
- R7: With even parity, the data bits and the parity bit together contain an even number of ones. With odd parity, they contain an odd number.
- R8: While `cts_n` is 1, no new frame starts and a held byte stays held. A frame already in progress is completed unchanged.
- R9: A byte that is held when a frame's last stop bit ends starts its own frame at that same boundary, with no idle bit between the frames.
- R10: The format and data of a frame are fixed when it starts. Changing `fmt_sel` during the frame does not change it.
- R11: In the 7-bit formats, bit 7 of `s_data` is not sent, and it is not counted in the parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle transmit clock tick |
| div_sel | input | 2 | Rate select: 00 /1, 01 /16, 10 /64, 11 master reset |
| fmt_sel | input | 3 | Frame format code (see R2) |
| cts_n | input | 1 | Clear to send, active low |
| s_data | input | 8 | Byte to transmit |
| s_valid | input | 1 | Byte on `s_data` is offered |
| s_ready | output | 1 | Holding register empty; byte accepted when high with `s_valid` |
| txd_out | output | 1 | Serial line, idle high |

## Verification
The assertions assume that `div_sel` changes only while no frame is on the line, or else toward or away from the master-reset value. They also assume that `tick_in` is a pulse in the system clock domain and not a level held across a rate change. The bench keeps to these assumptions: it changes the rate and the tick spacing only between frames, and it uses the master-reset value only as a deliberate abort. Frames are recovered by a model receiver that samples the line in the middle of each bit period, measured in ticks. `cts_n` and `fmt_sel` are moved during a frame only to show that the frame is not affected.

// File: rtl/tx_async_pkg.sv
package tx_async_pkg;

  localparam int MAX_DATA = 8;

  localparam logic [1:0] RATE_ONE   = 2'b00;
  localparam logic [1:0] RATE_MID   = 2'b01;
  localparam logic [1:0] RATE_HI    = 2'b10;
  localparam logic [1:0] RATE_RESET = 2'b11;

  typedef struct packed {
    logic [3:0] data_bits;
    logic       par_on;
    logic       par_odd;
    logic [1:0] stop_bits;
  } tx_fmt_t;

  // Eight-entry frame format table.
  function automatic tx_fmt_t fmt_decode(input logic [2:0] code);
    tx_fmt_t f;
    case (code)
      3'b000:  f = '{data_bits: 4'd7, par_on: 1'b1, par_odd: 1'b0, stop_bits: 2'd2};
      3'b001:  f = '{data_bits: 4'd7, par_on: 1'b1, par_odd: 1'b1, stop_bits: 2'd2};
      3'b010:  f = '{data_bits: 4'd7, par_on: 1'b1, par_odd: 1'b0, stop_bits: 2'd1};
      3'b011:  f = '{data_bits: 4'd7, par_on: 1'b1, par_odd: 1'b1, stop_bits: 2'd1};
      3'b100:  f = '{data_bits: 4'd8, par_on: 1'b0, par_odd: 1'b0, stop_bits: 2'd2};
      3'b101:  f = '{data_bits: 4'd8, par_on: 1'b0, par_odd: 1'b0, stop_bits: 2'd1};
      3'b110:  f = '{data_bits: 4'd8, par_on: 1'b1, par_odd: 1'b0, stop_bits: 2'd1};
      default: f = '{data_bits: 4'd8, par_on: 1'b1, par_odd: 1'b1, stop_bits: 2'd1};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/tx_rate_div.sv
module tx_rate_div #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick_in,
  input  logic [1:0] div_sel,
  output logic       bit_tick
);
  import tx_async_pkg::*;

  localparam int CNT_W = $clog2(DIV_HI);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   limit;
  logic             wrap;

  always_comb begin
    case (div_sel)
      RATE_ONE: limit = (CNT_W+1)'(1);
      RATE_MID: limit = (CNT_W+1)'(DIV_MID);
      default:  limit = (CNT_W+1)'(DIV_HI);
    endcase
  end

  assign wrap     = ({1'b0, cnt_q} >= (limit - (CNT_W+1)'(1)));
  assign bit_tick = tick_in && wrap && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] hold_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign full      = full_q;
  assign hold_data = data_q;
  assign wr_ready  = !full_q && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (wr_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end
  end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_async_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  tx_fmt_t           fmt,
  output logic              busy,
  output logic              free,
  output logic              txd
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  logic               par_bit;

  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    par_bit  = fmt.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(fmt.data_bits)) begin
        frame[1+i] = load_data[i];
        par_bit    = par_bit ^ load_data[i];
      end
    end
    for (int i = 0; i <= DATA_W; i++) begin
      if (fmt.par_on && (i == int'(fmt.data_bits))) begin
        frame[1+i] = par_bit;
      end
    end
    frame_len = LEN_W'(1) + LEN_W'(fmt.data_bits) + LEN_W'(fmt.par_on)
              + LEN_W'(fmt.stop_bits);
  end

  assign busy = busy_q;
  assign free = !busy_q || (left_q == LEN_W'(1));
  assign txd  = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (clr) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (bit_tick) begin
      if (load) begin
        sh_q   <= frame;
        left_q <= frame_len;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (left_q == LEN_W'(1)) begin
          sh_q   <= '1;
          left_q <= '0;
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - LEN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/tx_async_framer.sv
module tx_async_framer
  import tx_async_pkg::*;
#(
  parameter int DATA_W  = MAX_DATA,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [1:0]        div_sel,
  input  logic [2:0]        fmt_sel,
  input  logic              cts_n,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              txd_out
);

  logic              mres;
  logic              bit_tick;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              sh_busy;
  logic              sh_free;
  logic              frame_load;
  tx_fmt_t           cur_fmt;

  assign mres    = (div_sel == RATE_RESET);
  assign cur_fmt = fmt_decode(fmt_sel);

  assign frame_load = bit_tick && hold_full && sh_free && !cts_n;

  tx_rate_div #(
    .DIV_MID (DIV_MID),
    .DIV_HI  (DIV_HI)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mres),
    .tick_in  (tick_in),
    .div_sel  (div_sel),
    .bit_tick (bit_tick)
  );

  tx_hold_buf #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mres),
    .wr_valid  (s_valid),
    .wr_data   (s_data),
    .wr_ready  (s_ready),
    .take      (frame_load),
    .full      (hold_full),
    .hold_data (hold_data)
  );

  tx_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mres),
    .bit_tick  (bit_tick),
    .load      (frame_load),
    .load_data (hold_data),
    .fmt       (cur_fmt),
    .busy      (sh_busy),
    .free      (sh_free),
    .txd       (txd_out)
  );

endmodule

// File: rtl/tx_async_framer_chk.sv
module tx_async_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] div_sel,
  input logic       cts_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       txd_out,
  input logic       bit_tick,
  input logic       sh_busy,
  input logic       frame_load
);

  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_idle_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> txd_out);

  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (sh_busy && !txd_out));

  p_edge_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && div_sel != 2'b11) |=> $stable(txd_out));

  p_mres_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == 2'b11) |=> (txd_out && !sh_busy));

  p_cts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_n && !sh_busy) |=> !sh_busy);

endmodule

bind tx_async_framer tx_async_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_sel    (div_sel),
  .cts_n      (cts_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .txd_out    (txd_out),
  .bit_tick   (bit_tick),
  .sh_busy    (sh_busy),
  .frame_load (frame_load)
);

// File: tb/test_tx_async_framer.sv
module test_tx_async_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic [2:0] fmt_sel = 3'b000;
  logic       cts_n = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic       txd_out;

  int tests = 0;
  int fails = 0;
  int gap = 1;
  int tcnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tx_async_framer i_tx_async_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .div_sel (div_sel),
    .fmt_sel (fmt_sel),
    .cts_n   (cts_n),
    .s_data  (s_data),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .txd_out (txd_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      tick_in = (tcnt == 0);
      tcnt = (tcnt + 1 >= gap) ? 0 : tcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
  endfunction

  // Expected frame from the R2 table; unused positions stay 1.
  function automatic int exp_frame(input logic [2:0] f, input logic [7:0] b,
                                   output logic [11:0] v);
    int  nd, ns, idx;
    bit  pe, po, p;
    nd = f[2] ? 8 : 7;
    if (!f[2]) begin pe = 1; po = f[0]; ns = f[1] ? 1 : 2; end
    else begin pe = f[1]; po = f[1] & f[0]; ns = (f[1:0] == 2'b00) ? 2 : 1; end
    v = '1;
    v[0] = 1'b0;
    p = po;
    for (int i = 0; i < nd; i++) begin
      v[1+i] = b[i];
      p = p ^ b[i];
    end
    idx = 1 + nd;
    if (pe) begin v[idx] = p; idx++; end
    return idx + ns;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    int w = 0;
    @(negedge clk);
    while (!s_ready && w < 5000) begin @(negedge clk); w++; end
    s_valid = 1'b1;
    s_data  = b;
    @(negedge clk);
    s_valid = 1'b0;
    check(!s_ready, "R4 ready low after write", s_ready, 0);
  endtask

  // Model receiver: action 1 raises cts_n, 2 flips fmt_sel after the start bit.
  task automatic rx_frame(input int n, input int per, input int action,
                          output logic [11:0] got, output int t0);
    int w = 0;
    got = '1;
    t0 = -1;
    @(negedge clk);
    while (txd_out && w < 20000) begin @(negedge clk); w++; end
    if (txd_out) begin
      check(0, "R1 start bit timeout", 1, 0);
    end else begin
      t0 = cyc;
      check(s_ready, "R4 ready high at start bit", s_ready, 1);
      if (action == 1) cts_n = 1'b1;
      if (action == 2) fmt_sel = ~fmt_sel;
      for (int k = 0; k < n; k++) begin
        repeat ((k == 0) ? per / 2 : per) @(negedge clk);
        got[k] = txd_out;
      end
    end
  endtask

  task automatic one_frame(input logic [2:0] f, input logic [7:0] b, input string req);
    logic [11:0] v, g;
    int n, t0;
    fmt_sel = f;
    n = exp_frame(f, b, v);
    put_byte(b);
    rx_frame(n, div_of(div_sel) * gap, 0, g, t0);
    check(g == v, req, g, v);
  endtask

  initial begin
    logic [11:0] v1, v2, g1, g2;
    int n1, n2, ta, tb, any_low;

    repeat (5) @(negedge clk);
    check(txd_out == 1'b1, "R6 line high in reset", txd_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd_out == 1'b1, "R6 idle line", txd_out, 1);
    check(s_ready == 1'b1, "R4 ready after reset", s_ready, 1);

    // Sweep of every format over a spread of bytes at divide 1.
    for (int f = 0; f < 8; f++) begin
      for (int b = 0; b < 256; b += 17) begin
        one_frame(3'(f), 8'(b), "R1 R2 R7 R11 frame");
      end
      one_frame(3'(f), 8'hFF, "R1 R2 R7 R11 frame ff");
    end

    // Divide 16, every format.
    div_sel = 2'b01;
    for (int f = 0; f < 8; f++) one_frame(3'(f), 8'hC5 ^ 8'(f), "R3 divide 16 frame");

    // Divide 64.
    div_sel = 2'b10;
    one_frame(3'b111, 8'h96, "R3 divide 64 frame");

    // Divide 16 with a tick every third cycle.
    repeat (200) @(negedge clk);
    div_sel = 2'b01;
    gap = 3;
    repeat (100) @(negedge clk);
    one_frame(3'b110, 8'h3B, "R3 sparse tick frame");
    gap = 1;
    repeat (100) @(negedge clk);

    // Back-to-back frames at divide 16.
    fmt_sel = 3'b010;
    n1 = exp_frame(3'b010, 8'h4D, v1);
    n2 = exp_frame(3'b010, 8'hB2, v2);
    fork
      begin put_byte(8'h4D); put_byte(8'hB2); end
      begin rx_frame(n1, 16, 0, g1, ta); rx_frame(n2, 16, 0, g2, tb); end
    join
    check(g1 == v1, "R9 first frame", g1, v1);
    check(g2 == v2, "R9 second frame", g2, v2);
    check(tb - ta == n1 * 16, "R9 no gap between frames", tb - ta, n1 * 16);

    // Format change during a frame.
    fmt_sel = 3'b001;
    n1 = exp_frame(3'b001, 8'hE7, v1);
    put_byte(8'hE7);
    rx_frame(n1, 16, 2, g1, ta);
    check(g1 == v1, "R10 format latched at start", g1, v1);

    // CTS high holds the byte.
    repeat (40) @(negedge clk);
    div_sel = 2'b00;
    fmt_sel = 3'b101;
    cts_n = 1'b1;
    put_byte(8'h69);
    any_low = 0;
    repeat (300) begin @(negedge clk); if (!txd_out) any_low = 1; end
    check(any_low == 0, "R8 no frame while cts high", any_low, 0);
    check(s_ready == 1'b0, "R8 byte stays held", s_ready, 0);
    cts_n = 1'b0;
    n1 = exp_frame(3'b101, 8'h69, v1);
    rx_frame(n1, 1, 0, g1, ta);
    check(g1 == v1, "R8 frame after cts low", g1, v1);

    // CTS raised during a frame: the frame completes.
    div_sel = 2'b01;
    fmt_sel = 3'b000;
    n1 = exp_frame(3'b000, 8'h2A, v1);
    put_byte(8'h2A);
    rx_frame(n1, 16, 1, g1, ta);
    check(g1 == v1, "R8 frame in flight completes", g1, v1);
    cts_n = 1'b0;
    repeat (40) @(negedge clk);

    // Master reset in the middle of a frame.
    fmt_sel = 3'b100;
    put_byte(8'h00);
    while (txd_out) @(negedge clk);
    repeat (20) @(negedge clk);
    div_sel = 2'b11;
    @(negedge clk);
    check(txd_out == 1'b1, "R5 line idle after master reset", txd_out, 1);
    check(s_ready == 1'b0, "R5 ready low during master reset", s_ready, 0);
    div_sel = 2'b00;
    @(negedge clk);
    check(s_ready == 1'b1, "R5 ready after master reset", s_ready, 1);
    any_low = 0;
    repeat (60) begin @(negedge clk); if (!txd_out) any_low = 1; end
    check(any_low == 0, "R5 R6 line stays idle", any_low, 0);

    // Master reset discards a held byte.
    cts_n = 1'b1;
    put_byte(8'h55);
    div_sel = 2'b11;
    repeat (2) @(negedge clk);
    div_sel = 2'b00;
    cts_n = 1'b0;
    any_low = 0;
    repeat (200) begin @(negedge clk); if (!txd_out) any_low = 1; end
    check(any_low == 0, "R5 held byte discarded", any_low, 0);
    check(s_ready == 1'b1, "R5 buffer empty", s_ready, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule